// File: doc/BRIEF.md
# Segment Address Decoder

This block sits at the front of a shared-memory interconnect. It inspects the address an initiator presents and reports which target owns that address, whether the address lies in a cacheable region, and whether the address belongs to no known region at all. The set of regions is fixed when the design is built and is given as parameter tables. Each region has a base, a power-of-two byte size, a cacheable flag and an owning target number.

Several regions may belong to the same target, but no region may stretch across two targets. The target number comes from a small lookup table indexed by the top `LOOKUP_BITS` of the address. That table is computed from the region list during elaboration. Per-region range compares run alongside the table and decide whether the address hits anything.

All results are registered and appear one clock after the address is strobed, together with a copy of the strobe. Elaboration fails on tables that contain overlapping regions, misaligned regions, out-of-range owners, or two regions with different owners sharing one lookup slot.

The default table has four regions:

| Region | Range (hex) | Owner | Cacheable |
|---|---|---|---|
| Boot region | BFC00000 to BFFFFFFF | target 0 | yes |
| Code region | 00000000 to 00FFFFFF | target 0 | yes |
| Data region | 10000000 to 100FFFFF | target 1 | no |
| Device region | 20000000 to 20000FFF | target 2 | no |

Top module: `segdec_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `outValid`, `tgtIdx`, `tgtOneHot`, `cacheable` and `decErr` are all zero.
- R2: `outValid` in cycle n+1 equals `addrValid` in cycle n.
- R3: When a strobed address lies inside a region, the next cycle shows the region's owner on `tgtIdx` (binary) and `tgtOneHot` (bit k set for target k), and `decErr` is 0.
- R4: On a hit, `cacheable` equals the matched region's cacheable flag.
- R5: When a strobed address lies in no region, the next cycle shows `decErr` = 1, `tgtOneHot` = 0, `tgtIdx` = 0 and `cacheable` = 0.
- R6: A cycle without `addrValid` gives zero on all four data outputs in the following cycle.
- R7: A region's first and last byte decode as hits. The byte before its base and the byte after its end decode as misses, unless another region covers them.
- R8: In the default table, address 0xBFC00000 hits a cacheable region owned by target 0.
- R9: In the default table, the code region and the boot region both decode to target 0.
- R10: `tgtOneHot` never has more than one bit set. While `outValid` is 1 and `decErr` is 0, exactly one bit of `tgtOneHot` is set, and it is bit number `tgtIdx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| addrValid | input | 1 | Address strobe |
| addr | input | ADDR_W | Initiator address |
| outValid | output | 1 | Strobe delayed by one cycle |
| tgtIdx | output | TGT_W | Owning target, binary |
| tgtOneHot | output | NUM_TGT | Owning target, one bit per target |
| cacheable | output | 1 | Matched region is cacheable |
| decErr | output | 1 | Address matched no region |

## Verification
The assertions assume that `addrValid` is held low while reset is asserted. They also assume that the parameter table passed the elaboration checks, so that at most one region can match any address. The bench keeps the strobe low during reset and uses only the default table, which has no overlaps. Its sweep runs through every lookup slot, with offsets at the edges of each region, and inserts idle cycles to exercise the clearing path.

// File: rtl/segdec_pkg.sv
package segdec_pkg;

  typedef struct packed {
    logic load;
    logic clear;
  } dpCtrlT;

  function automatic logic rangesMeet(logic [63:0] baseA, int lgA,
                                      logic [63:0] baseB, int lgB);
    int wide;
    wide = (lgA > lgB) ? lgA : lgB;
    return (baseA >> wide) == (baseB >> wide);
  endfunction

endpackage

// File: rtl/segdec_ctrl.sv
module segdec_ctrl
  import segdec_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   addrValid,
  output logic   outValid,
  output dpCtrlT dpCtrl
);

  always_comb begin
    dpCtrl.load  = addrValid;
    dpCtrl.clear = !addrValid && outValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= addrValid;
  end

endmodule

// File: rtl/segdec_datapath.sv
module segdec_datapath
  import segdec_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LOOKUP_BITS = 4,
  parameter int NUM_SEG     = 4,
  parameter int NUM_TGT     = 3,
  parameter logic [NUM_SEG-1:0][ADDR_W-1:0] SEG_BASE = '0,
  parameter logic [NUM_SEG-1:0][7:0]        SEG_LG   = '0,
  parameter logic [NUM_SEG-1:0]             SEG_CACHE = '0,
  parameter logic [NUM_SEG-1:0][7:0]        SEG_TGT  = '0,
  localparam int TGT_W = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  addr,
  input  dpCtrlT             dpCtrl,
  output logic [TGT_W-1:0]   tgtIdx,
  output logic [NUM_TGT-1:0] tgtOneHot,
  output logic               cacheable,
  output logic               decErr
);

  localparam int SLOT_LG   = ADDR_W - LOOKUP_BITS;
  localparam int NUM_SLOTS = 1 << LOOKUP_BITS;

  function automatic logic segInSlot(int seg, int slot);
    return rangesMeet(64'(SEG_BASE[seg]), int'(SEG_LG[seg]),
                      64'(slot) << SLOT_LG, SLOT_LG);
  endfunction

  function automatic logic [7:0] slotOwner(int slot);
    for (int i = 0; i < NUM_SEG; i++)
      if (segInSlot(i, slot)) return SEG_TGT[i];
    return 8'd0;
  endfunction

  // Per-region range compare
  logic [NUM_SEG-1:0] segHit;

  for (genvar i = 0; i < NUM_SEG; i++) begin : g_seg
    localparam int LG = int'(SEG_LG[i]);
    if (LG >= ADDR_W) begin : g_badSize
      $error("region %0d is larger than the address space", i);
    end else begin : g_cmp
      assign segHit[i] = (addr[ADDR_W-1:LG] == SEG_BASE[i][ADDR_W-1:LG]);
      if ((64'(SEG_BASE[i]) & ((64'd1 << LG) - 64'd1)) != 64'd0) begin : g_misaligned
        $error("region %0d base is not aligned to its size", i);
      end
    end
    if (int'(SEG_TGT[i]) >= NUM_TGT) begin : g_badOwner
      $error("region %0d owner out of range", i);
    end
    for (genvar j = i + 1; j < NUM_SEG; j++) begin : g_pair
      if (rangesMeet(64'(SEG_BASE[i]), int'(SEG_LG[i]),
                     64'(SEG_BASE[j]), int'(SEG_LG[j]))) begin : g_overlap
        $error("regions %0d and %0d overlap", i, j);
      end
    end
  end

  // Slot lookup table of owning targets
  logic [NUM_SLOTS-1:0][TGT_W-1:0] slotRom;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    localparam logic [7:0] OWNER = slotOwner(s);
    assign slotRom[s] = OWNER[TGT_W-1:0];
    for (genvar i = 0; i < NUM_SEG; i++) begin : g_agree
      if (segInSlot(i, s) && (SEG_TGT[i] != OWNER)) begin : g_conflict
        $error("slot %0d holds regions with different owners", s);
      end
    end
  end

  logic [LOOKUP_BITS-1:0] slotSel;
  logic [TGT_W-1:0]       romTgt;
  logic                   anyHit;
  logic                   hitCache;
  logic [NUM_TGT-1:0]     oneHotNext;

  always_comb begin
    slotSel  = addr[ADDR_W-1 -: LOOKUP_BITS];
    romTgt   = slotRom[slotSel];
    anyHit   = |segHit;
    hitCache = |(segHit & SEG_CACHE);
    oneHotNext = '0;
    for (int t = 0; t < NUM_TGT; t++)
      if (anyHit && (romTgt == TGT_W'(t))) oneHotNext[t] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tgtIdx    <= '0;
      tgtOneHot <= '0;
      cacheable <= 1'b0;
      decErr    <= 1'b0;
    end else if (dpCtrl.load) begin
      tgtIdx    <= anyHit ? romTgt : '0;
      tgtOneHot <= oneHotNext;
      cacheable <= hitCache;
      decErr    <= !anyHit;
    end else if (dpCtrl.clear) begin
      tgtIdx    <= '0;
      tgtOneHot <= '0;
      cacheable <= 1'b0;
      decErr    <= 1'b0;
    end
  end

endmodule

// File: rtl/segdec_top.sv
module segdec_top
  import segdec_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LOOKUP_BITS = 4,
  parameter int NUM_SEG     = 4,
  parameter int NUM_TGT     = 3,
  parameter logic [NUM_SEG-1:0][ADDR_W-1:0] SEG_BASE =
    {32'h2000_0000, 32'h1000_0000, 32'h0000_0000, 32'hBFC0_0000},
  parameter logic [NUM_SEG-1:0][7:0] SEG_LG  = {8'd12, 8'd20, 8'd24, 8'd22},
  parameter logic [NUM_SEG-1:0]      SEG_CACHE = 4'b0011,
  parameter logic [NUM_SEG-1:0][7:0] SEG_TGT = {8'd2, 8'd1, 8'd0, 8'd0},
  localparam int TGT_W = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               addrValid,
  input  logic [ADDR_W-1:0]  addr,
  output logic               outValid,
  output logic [TGT_W-1:0]   tgtIdx,
  output logic [NUM_TGT-1:0] tgtOneHot,
  output logic               cacheable,
  output logic               decErr
);

  dpCtrlT dpCtrl;

  segdec_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .addrValid (addrValid),
    .outValid  (outValid),
    .dpCtrl    (dpCtrl)
  );

  segdec_datapath #(
    .ADDR_W      (ADDR_W),
    .LOOKUP_BITS (LOOKUP_BITS),
    .NUM_SEG     (NUM_SEG),
    .NUM_TGT     (NUM_TGT),
    .SEG_BASE    (SEG_BASE),
    .SEG_LG      (SEG_LG),
    .SEG_CACHE   (SEG_CACHE),
    .SEG_TGT     (SEG_TGT)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .addr      (addr),
    .dpCtrl    (dpCtrl),
    .tgtIdx    (tgtIdx),
    .tgtOneHot (tgtOneHot),
    .cacheable (cacheable),
    .decErr    (decErr)
  );

endmodule

// File: rtl/segdec_checker.sv
module segdec_checker #(
  parameter int NUM_TGT = 3,
  localparam int TGT_W = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1
)(
  input logic               clk,
  input logic               rstN,
  input logic               addrValid,
  input logic               outValid,
  input logic [TGT_W-1:0]   tgtIdx,
  input logic [NUM_TGT-1:0] tgtOneHot,
  input logic               cacheable,
  input logic               decErr
);

  AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    addrValid |=> outValid); // R2
  AST_STROBE_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    !addrValid |=> !outValid); // R2
  AST_MISS_SELECTS_NONE: assert property (@(posedge clk) disable iff (!rstN)
    decErr |-> (tgtOneHot == '0 && !cacheable && tgtIdx == '0)); // R5
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (tgtOneHot == '0 && tgtIdx == '0 && !cacheable && !decErr)); // R6
  AST_SELECT_ONEHOT0: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(tgtOneHot)); // R10
  AST_HIT_ONE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !decErr) |-> ($countones(tgtOneHot) == 1)); // R10
  AST_HIT_INDEX_AGREES: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !decErr) |-> tgtOneHot[tgtIdx]); // R10

endmodule

bind segdec_top segdec_checker #(.NUM_TGT(NUM_TGT)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .addrValid (addrValid),
  .outValid  (outValid),
  .tgtIdx    (tgtIdx),
  .tgtOneHot (tgtOneHot),
  .cacheable (cacheable),
  .decErr    (decErr)
);

// File: tb/sim_segdec_top.sv
module sim_segdec_top;

  localparam int NT = 3;
  localparam int NS = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        addrValid = 1'b0;
  logic [31:0] addr = '0;
  logic        outValid;
  logic [1:0]  tgtIdx;
  logic [NT-1:0] tgtOneHot;
  logic        cacheable;
  logic        decErr;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // independent copy of the default region list
  longint unsigned bases [NS] = '{64'hBFC0_0000, 64'h0, 64'h1000_0000, 64'h2000_0000};
  int              lgs   [NS] = '{22, 24, 20, 12};
  int              owner [NS] = '{0, 0, 1, 2};
  bit              cach  [NS] = '{1, 1, 0, 0};

  always #10 clk = ~clk;

  segdec_top u0 (
    .clk(clk), .rstN(rstN), .addrValid(addrValid), .addr(addr),
    .outValid(outValid), .tgtIdx(tgtIdx), .tgtOneHot(tgtOneHot),
    .cacheable(cacheable), .decErr(decErr)
  );

  task automatic chk(string req, longint unsigned act, longint unsigned exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic step(logic v, logic [31:0] a);
    addrValid = v;
    addr = a;
    @(posedge clk);
    #2;
  endtask

  task automatic expectAddr(logic [31:0] a);
    int seg;
    seg = -1;
    for (int i = 0; i < NS; i++)
      if ((longint'(a) >> lgs[i]) == (bases[i] >> lgs[i])) seg = i;
    step(1'b1, a);
    chk("R2 outValid", outValid, 1);
    if (seg >= 0) begin
      chk("R3 tgtIdx", tgtIdx, owner[seg]);
      chk("R3 tgtOneHot", tgtOneHot, 1 << owner[seg]);
      chk("R3 decErr", decErr, 0);
      chk("R4 cacheable", cacheable, cach[seg]);
    end else begin
      chk("R5 decErr", decErr, 1);
      chk("R5 tgtOneHot", tgtOneHot, 0);
      chk("R5 tgtIdx", tgtIdx, 0);
      chk("R5 cacheable", cacheable, 0);
    end
  endtask

  task automatic expectIdle();
    step(1'b0, 32'hBFC0_0000);
    chk("R6 outValid", outValid, 0);
    chk("R6 data", {tgtIdx, tgtOneHot, cacheable, decErr}, 0);
  endtask

  initial begin
    int offs [15] = '{32'h0, 32'hFFF, 32'h1000, 32'hFFFFF, 32'h100000,
                      32'h3FFFFF, 32'h400000, 32'hBFFFFF, 32'hC00000,
                      32'hFFFFFF, 32'h1000000, 32'hFBFFFFF, 32'hFC00000,
                      32'hFFFFFFF, 32'h7654321};
    repeat (3) @(posedge clk);
    #2;
    chk("R1 during reset", {outValid, tgtIdx, tgtOneHot, cacheable, decErr}, 0);
    rstN = 1'b1;
    step(1'b0, 32'h0);
    chk("R1 after release", {outValid, tgtIdx, tgtOneHot, cacheable, decErr}, 0);

    // R8: boot region
    step(1'b1, 32'hBFC0_0000);
    chk("R8 tgtIdx", tgtIdx, 0);
    chk("R8 cacheable", cacheable, 1);
    chk("R8 decErr", decErr, 0);
    // R9: two regions sharing target 0
    step(1'b1, 32'h0000_1234);
    chk("R9 code owner", tgtIdx, 0);
    step(1'b1, 32'hBFFF_FFFC);
    chk("R9 boot owner", tgtIdx, 0);

    // R7: region edges
    for (int i = 0; i < NS; i++) begin
      longint unsigned lo = bases[i];
      longint unsigned hi = bases[i] + (64'd1 << lgs[i]);
      step(1'b1, lo[31:0]);
      chk("R7 first byte hit", decErr, 0);
      step(1'b1, 32'(hi - 1));
      chk("R7 last byte hit", decErr, 0);
      if (lo != 0) begin
        step(1'b1, 32'(lo - 1));
        chk("R7 before base", decErr, (i == 2 || i == 3) ? 1 : 1);
      end
      step(1'b1, 32'(hi));
      chk("R7 past end", decErr, 1);
    end

    // sweep every lookup slot with edge offsets
    for (int s = 0; s < 16; s++) begin
      for (int k = 0; k < 15; k++) begin
        expectAddr({s[3:0], 28'h0} | offs[k][27:0]);
        if (k % 4 == 3) expectIdle();
      end
    end
    expectIdle();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule